// File: doc/BRIEF.md
# Execution Mode and Operand/Address Size Resolver

This block takes the architectural control bits of a processor core and works out which execution mode the core is in. The inputs are the long-mode-active flag, the protection-enable bit, the virtual-8086 flag, and the L and D attributes of the current code segment. From that mode and the decoded prefix indicators of one instruction, it produces the effective address size and the effective operand size. The prefix indicators are the 66h and 67h prefixes, REX.W, a default-64 class hint for stack and near-branch instructions, and a forced-64 hint for control/debug register moves.

The decode path sits behind an input valid/ready handshake. An accepted request is registered, and its results appear one cycle later with a one-cycle output valid pulse. The registered results hold until the next request is accepted. Any combination of inputs the mode rules do not cover is reported as an error instead of a size.

Top module: `mode_size_resolver`

## Requirements
- R1: While reset is asserted, `out_valid` and `in_ready` are 0. From the first clock edge after reset is released, `in_ready` is 1.
- R2: A request accepted at a clock edge (`in_valid`=1 and `in_ready`=1) produces `out_valid`=1 after that edge, for exactly one cycle. With no acceptance, `out_valid` is 0 and `mode`, `addr_size`, `op_size`, `rsvd` and `err` keep their previous values.
- R3: When `lma`=0, the mode is decided as follows, and `cs_l` is ignored:
  - `pe`=0 gives real (`mode`=0).
  - `pe`=1 with `vm`=1 gives virtual-8086 (`mode`=1).
  - `pe`=1 with `vm`=0 gives protected-16 (`mode`=2) when `cs_d`=0, or protected-32 (`mode`=3) when `cs_d`=1.
  - Real and virtual-8086 ignore `cs_d`.
- R4: With `lma`=1, `pe`=1 and `vm`=0:
  - `cs_l`=1 with `cs_d`=0 gives 64-bit mode (`mode`=6).
  - `cs_l`=0 gives compatibility-16 (`mode`=4) when `cs_d`=0, or compatibility-32 (`mode`=5) when `cs_d`=1.
- R5: In modes 0 to 5 the default address size is 16 for modes 0, 1, 2 and 4, and 32 for modes 3 and 5. `pfx_67`=1 swaps 16 and 32. Size codes are 0=16, 1=32, 2=64 and 3=none.
- R6: In mode 6 the address size is 64 (code 2), or 32 (code 1) when `pfx_67`=1.
- R7: In modes 0 to 5 the operand size starts from the same default as the address size, and `pfx_66`=1 swaps 16 and 32. `rex_w`, `dflt64` and `force64` have no effect.
- R8: In mode 6 with neither hint set, the operand size is 32. `pfx_66`=1 gives 16. `rex_w`=1 gives 64, whether or not `pfx_66` is set.
- R9: In mode 6 with `dflt64`=1, the operand size is 64. The one exception is `pfx_66`=1 with `rex_w`=0, which gives 16.
- R10: In mode 6 with `force64`=1, the operand size is 64, whatever `pfx_66` and `rex_w` are.
- R11: `rsvd`=1 exactly when `lma`=1, `cs_l`=1 and `cs_d`=1. Such a request also gives `err`=1, `mode`=7 and both sizes 3.
- R12: The following also give `err`=1, `mode`=7 and both sizes 3:
  - `lma`=1 with `pe`=0.
  - `lma`=1 with `vm`=1.
  - `dflt64`=1 together with `force64`=1, in any mode.

  For all other requests `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block accepts a request |
| lma | input | 1 | Long-mode-active flag |
| pe | input | 1 | Protection-enable bit |
| vm | input | 1 | Virtual-8086 flag |
| cs_l | input | 1 | Code segment L attribute |
| cs_d | input | 1 | Code segment D attribute |
| pfx_66 | input | 1 | Operand-size prefix present |
| pfx_67 | input | 1 | Address-size prefix present |
| rex_w | input | 1 | REX.W set |
| dflt64 | input | 1 | Instruction class defaults to 64-bit operands |
| force64 | input | 1 | Control/debug register move, forced to 64 bits |
| out_valid | output | 1 | Results valid this cycle |
| mode | output | 3 | Mode code 0..6, or 7 on error |
| addr_size | output | 2 | Effective address size code |
| op_size | output | 2 | Effective operand size code |
| rsvd | output | 1 | Reserved L=1/D=1 combination in long mode |
| err | output | 1 | Request not covered by the mode rules |

## Verification
Every result is registered once, so the results of a request driven before a rising edge are due just after that edge. The bench drives inputs on the falling edge and checks `out_valid` and every result field on the next falling edge, half a cycle after the capturing edge. On cycles without acceptance, the same falling-edge sample compares the fields against the last accepted result, which checks that they hold.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int MODE_W = 3;
    localparam int SIZE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_REAL     = 3'd0,
        MD_V86      = 3'd1,
        MD_PROT16   = 3'd2,
        MD_PROT32   = 3'd3,
        MD_COMPAT16 = 3'd4,
        MD_COMPAT32 = 3'd5,
        MD_LONG64   = 3'd6,
        MD_BAD      = 3'd7
    } mode_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_16   = 2'd0,
        SZ_32   = 2'd1,
        SZ_64   = 2'd2,
        SZ_NONE = 2'd3
    } size_e;

    typedef struct packed {
        logic  vld;
        mode_e mode;
        size_e asz;
        size_e osz;
        logic  rsvd;
        logic  err;
    } res_t;
endpackage

// File: rtl/msr_mode_classify.sv
module msr_mode_classify
    import msr_pkg::*;
(
    input  logic  lma,
    input  logic  pe,
    input  logic  vm,
    input  logic  cs_l,
    input  logic  cs_d,
    input  logic  dflt64,
    input  logic  force64,
    output mode_e mode,
    output logic  rsvd,
    output logic  bad
);
    logic hint_clash;
    logic long_bad;

    always_comb begin
        hint_clash = dflt64 & force64;
        rsvd       = lma & cs_l & cs_d;
        long_bad   = lma & (~pe | vm | (cs_l & cs_d));
        bad        = hint_clash | long_bad;
        mode       = MD_BAD;
        if (!bad) begin
            if (lma) begin
                if (cs_l)      mode = MD_LONG64;
                else if (cs_d) mode = MD_COMPAT32;
                else           mode = MD_COMPAT16;
            end else begin
                if (!pe)       mode = MD_REAL;
                else if (vm)   mode = MD_V86;
                else if (cs_d) mode = MD_PROT32;
                else           mode = MD_PROT16;
            end
        end
    end
endmodule

// File: rtl/msr_size_resolve.sv
module msr_size_resolve
    import msr_pkg::*;
(
    input  mode_e mode,
    input  logic  pfx_66,
    input  logic  pfx_67,
    input  logic  rex_w,
    input  logic  dflt64,
    input  logic  force64,
    output size_e asz,
    output size_e osz
);
    logic def32;

    always_comb begin
        def32 = (mode == MD_PROT32) || (mode == MD_COMPAT32);
        asz   = SZ_NONE;
        osz   = SZ_NONE;
        if (mode == MD_LONG64) begin
            asz = pfx_67 ? SZ_32 : SZ_64;
            if (force64)                 osz = SZ_64;
            else if (rex_w)              osz = SZ_64;
            else if (pfx_66)             osz = SZ_16;
            else if (dflt64)             osz = SZ_64;
            else                         osz = SZ_32;
        end else if (mode != MD_BAD) begin
            asz = (def32 ^ pfx_67) ? SZ_32 : SZ_16;
            osz = (def32 ^ pfx_66) ? SZ_32 : SZ_16;
        end
    end
endmodule

// File: rtl/mode_size_resolver.sv
module mode_size_resolver
    import msr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       lma,
    input  logic       pe,
    input  logic       vm,
    input  logic       cs_l,
    input  logic       cs_d,
    input  logic       pfx_66,
    input  logic       pfx_67,
    input  logic       rex_w,
    input  logic       dflt64,
    input  logic       force64,
    output logic       out_valid,
    output logic [2:0] mode,
    output logic [1:0] addr_size,
    output logic [1:0] op_size,
    output logic       rsvd,
    output logic       err
);
    mode_e mode_c;
    size_e asz_c;
    size_e osz_c;
    logic  rsvd_c;
    logic  bad_c;
    logic  take;
    logic  rdy_d, rdy_q;
    res_t  res_d, res_q;

    msr_mode_classify u_cls (
        .lma(lma), .pe(pe), .vm(vm), .cs_l(cs_l), .cs_d(cs_d),
        .dflt64(dflt64), .force64(force64),
        .mode(mode_c), .rsvd(rsvd_c), .bad(bad_c)
    );

    msr_size_resolve u_sz (
        .mode(mode_c), .pfx_66(pfx_66), .pfx_67(pfx_67), .rex_w(rex_w),
        .dflt64(dflt64), .force64(force64),
        .asz(asz_c), .osz(osz_c)
    );

    always_comb begin
        take      = in_valid & rdy_q;
        rdy_d     = 1'b1;
        res_d     = res_q;
        res_d.vld = take;
        if (take) begin
            res_d.mode = mode_c;
            res_d.asz  = asz_c;
            res_d.osz  = osz_c;
            res_d.rsvd = rsvd_c;
            res_d.err  = bad_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            rdy_q <= 1'b0;
        end else begin
            res_q <= res_d;
            rdy_q <= rdy_d;
        end
    end

    assign in_ready  = rdy_q;
    assign out_valid = res_q.vld;
    assign mode      = res_q.mode;
    assign addr_size = res_q.asz;
    assign op_size   = res_q.osz;
    assign rsvd      = res_q.rsvd;
    assign err       = res_q.err;

    AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> (!out_valid && $stable(mode) && $stable(op_size))); // R2
    AST_REAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !lma && !pe && !(dflt64 && force64)) |=> (mode == 3'd0 && !err)); // R3
    AST_LONG_ADDR_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode == 3'd6) |-> (addr_size == 2'd1 || addr_size == 2'd2)); // R6
    AST_LEGACY_NO_64: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !err && mode != 3'd6) |-> (addr_size != 2'd2 && op_size != 2'd2)); // R7
    AST_ERR_NO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err) |-> (mode == 3'd7 && addr_size == 2'd3 && op_size == 2'd3)); // R12
    AST_RSVD_IS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rsvd) |-> err); // R11
endmodule

// File: tb/test_mode_size_resolver.sv
module test_mode_size_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       lma = 0, pe = 0, vm = 0, cs_l = 0, cs_d = 0;
    logic       pfx_66 = 0, pfx_67 = 0, rex_w = 0, dflt64 = 0, force64 = 0;
    logic       out_valid;
    logic [2:0] mode;
    logic [1:0] addr_size, op_size;
    logic       rsvd, err;

    int n_chk = 0;
    int n_err = 0;

    logic [2:0] exp_mode = 3'd0;
    logic [1:0] exp_asz = 2'd0, exp_osz = 2'd0;
    logic       exp_rsvd = 1'b0, exp_err = 1'b0, exp_vld = 1'b0;

    always #4 clk = ~clk;

    mode_size_resolver i_mode_size_resolver (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .lma(lma), .pe(pe), .vm(vm), .cs_l(cs_l), .cs_d(cs_d),
        .pfx_66(pfx_66), .pfx_67(pfx_67), .rex_w(rex_w),
        .dflt64(dflt64), .force64(force64),
        .out_valid(out_valid), .mode(mode), .addr_size(addr_size),
        .op_size(op_size), .rsvd(rsvd), .err(err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected results derived from R3..R12
    task automatic model();
        logic bad, d32;
        exp_rsvd = lma & cs_l & cs_d;
        bad = (dflt64 & force64) | (lma & (~pe | vm | (cs_l & cs_d)));
        exp_err = bad;
        if (bad) begin
            exp_mode = 3'd7; exp_asz = 2'd3; exp_osz = 2'd3;
        end else if (lma && cs_l) begin
            exp_mode = 3'd6;
            exp_asz  = pfx_67 ? 2'd1 : 2'd2;
            if (force64 || rex_w) exp_osz = 2'd2;
            else if (pfx_66)      exp_osz = 2'd0;
            else if (dflt64)      exp_osz = 2'd2;
            else                  exp_osz = 2'd1;
        end else begin
            if (lma)        exp_mode = cs_d ? 3'd5 : 3'd4;
            else if (!pe)   exp_mode = 3'd0;
            else if (vm)    exp_mode = 3'd1;
            else            exp_mode = cs_d ? 3'd3 : 3'd2;
            d32 = (exp_mode == 3'd3) || (exp_mode == 3'd5);
            exp_asz = (d32 ^ pfx_67) ? 2'd1 : 2'd0;
            exp_osz = (d32 ^ pfx_66) ? 2'd1 : 2'd0;
        end
    endtask

    function automatic string tag_mode();
        if (exp_err) return exp_rsvd ? "R11" : "R12";
        return (exp_mode >= 3'd4) ? "R4" : "R3";
    endfunction

    function automatic string tag_asz();
        if (exp_err) return exp_rsvd ? "R11" : "R12";
        return (exp_mode == 3'd6) ? "R6" : "R5";
    endfunction

    function automatic string tag_osz();
        if (exp_err) return exp_rsvd ? "R11" : "R12";
        if (exp_mode != 3'd6) return "R7";
        if (force64) return "R10";
        if (dflt64) return "R9";
        return "R8";
    endfunction

    // Compare outputs half a cycle after the capturing edge
    task automatic check_outputs(input string mt, input string at, input string ot);
        string vt;
        vt = exp_vld ? "R2" : "R2_hold";
        check("R2", "out_valid", out_valid, exp_vld);
        check(exp_vld ? mt : vt, "mode", mode, exp_mode);
        check(exp_vld ? at : vt, "addr_size", addr_size, exp_asz);
        check(exp_vld ? ot : vt, "op_size", op_size, exp_osz);
        check(exp_vld ? "R11" : vt, "rsvd", rsvd, exp_rsvd);
        check(exp_vld ? mt : vt, "err", err, exp_err);
    endtask

    // Drive one request at a falling edge, then check at the next one
    task automatic step(input logic v, input logic [9:0] b);
        string mt, at, ot;
        in_valid = v;
        {lma, pe, vm, cs_l, cs_d, pfx_66, pfx_67, rex_w, dflt64, force64} = b;
        if (v) begin
            model();
            mt = tag_mode(); at = tag_asz(); ot = tag_osz();
        end else begin
            mt = "R2"; at = "R2"; ot = "R2";
        end
        exp_vld = v;
        @(negedge clk);
        check_outputs(mt, at, ot);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", out_valid, 0);
        check("R1", "in_ready in reset", in_ready, 0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", "in_ready after reset", in_ready, 1);
        check("R1", "out_valid after reset", out_valid, 0);

        // Directed corners: bits {lma,pe,vm,l,d,66,67,w,d64,f64}
        step(1, 10'b00000_00000); // R3 real
        step(1, 10'b00001_00000); // R3 real ignores D
        step(1, 10'b01101_11000); // R3 v86 with both prefixes
        step(1, 10'b01001_00000); // R3 prot32
        step(1, 10'b01000_01000); // R5 prot16 with 67h
        step(1, 10'b01010_10110); // R7 prot16: L, REX.W, dflt64 ignored
        step(1, 10'b11000_00000); // R4 compat16
        step(1, 10'b11001_10001); // R7 compat32 66h, force64 ignored
        step(1, 10'b11010_00000); // R6 R8 long default
        step(1, 10'b11010_01000); // R6 67h -> 32
        step(1, 10'b11010_10000); // R8 66h -> 16
        step(1, 10'b11010_10100); // R8 REX.W beats 66h
        step(1, 10'b11010_00010); // R9 dflt64 -> 64
        step(1, 10'b11010_10010); // R9 dflt64 with 66h -> 16
        step(1, 10'b11010_10110); // R9 dflt64 66h REX.W -> 64
        step(1, 10'b11010_10001); // R10 force64 with 66h
        step(1, 10'b11011_00000); // R11 reserved L=1 D=1
        step(1, 10'b10010_00000); // R12 lma without pe
        step(1, 10'b11110_00000); // R12 lma with vm
        step(1, 10'b01001_00011); // R12 both hints
        step(0, 10'b11010_10100); // R2 hold after error
        step(0, 10'b00000_00000); // R2 hold again
        step(1, 10'b11010_00000); // R2 valid again

        for (int i = 0; i < 3000; i++) begin
            logic [9:0] b;
            b = 10'($urandom);
            if (($urandom % 4) != 0) b[9:5] = ($urandom % 2) ? 5'b11010 : 5'($urandom);
            step(($urandom % 4) != 0, b);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule